// File: doc/BRIEF.md
# Interval-Based Hot Window Selector

This block supports intra-set wear leveling in a last-level cache whose ways are grouped into logical windows, a window being a vertical slice of several ways across all sets. It keeps one saturating write counter per window. A counter advances by one each time the cache datapath reports a performed write into a way of that window. That includes writes the datapath redirected into the window.

A free-running cycle timer divides time into intervals of fixed length. During the first interval after reset no window is restricted, and the valid output stays low. At the last cycle of each interval the block searches the counters for the largest value. It publishes that window as write-restricted for the next interval and clears only that window's counter. The other counters keep their history across intervals. The datapath reads the restricted index and steers writes that hit the window elsewhere.

Top module: `hot_window_selector`

## Requirements
- R1: While reset (rst_n low) is applied and in the first cycle after it, rsv_valid_o is 0 and rsv_win_o is 0.
- R2: rsv_valid_o stays 0 for the first INTERVAL cycles after reset release. It becomes 1 in the cycle following the INTERVAL-th cycle and remains 1 until the next reset.
- R3: At each interval boundary, meaning the INTERVAL-th cycle of every interval, the window whose counter is largest is published on rsv_win_o in the next cycle. The output then holds unchanged through the whole interval.
- R4: When several counters share the largest value, including all counters being zero, the window with the lowest index is selected.
- R5: At a boundary only the selected window's counter is cleared. Every other counter keeps its value into the next interval.
- R6: A cycle with wr_evt_i high adds one to the counter of window wr_win_i. A cycle with wr_evt_i low changes no counter.
- R7: A counter that has reached 2^CNT_W-1 stays there on further writes and does not wrap.
- R8: A write strobed in a boundary cycle is counted before the maximum search. If its window is selected, that counter is still cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_evt_i | input | 1 | A write was performed in the cache this cycle |
| wr_win_i | input | $clog2(NUM_WIN) | Index of the window that absorbed the write |
| rsv_win_o | output | $clog2(NUM_WIN) | Index of the write-restricted window |
| rsv_valid_o | output | 1 | A restricted window is in force |

## Verification
The counters are visible only through the choice made at each boundary, so the hardest case is saturation. A saturated counter must still win a comparison that a wrapped counter would lose. The stimulus uses a 4-bit counter and a 32-cycle interval. In the first interval it gives window 0 twenty writes and window 1 ten writes, so only a saturating counter (15 against 10) selects window 0. A boundary-cycle write is driven onto a window tied with a lower-numbered one, so that the outcome shows whether that write entered the comparison.

// File: rtl/hws_pkg.sv
package hws_pkg;

    // Saturating increment on a generic width carried in 32 bits.
    function automatic logic [31:0] sat_inc(input logic [31:0] value,
                                            input logic [31:0] limit);
        if (value >= limit) begin
            return limit;
        end
        return value + 32'd1;
    endfunction

endpackage

// File: rtl/hws_interval_timer.sv
module hws_interval_timer #(
    parameter int INTERVAL = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic boundary_o
);
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == LAST) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign boundary_o = (tmr_q.cnt == LAST);

endmodule

// File: rtl/hws_win_counters.sv
module hws_win_counters #(
    parameter int NUM_WIN = 4,
    parameter int CNT_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_evt_i,
    input  logic [$clog2(NUM_WIN)-1:0] wr_win_i,
    input  logic                       clr_en_i,
    input  logic [$clog2(NUM_WIN)-1:0] clr_idx_i,
    output logic [NUM_WIN*CNT_W-1:0]   eff_o
);
    import hws_pkg::*;

    localparam int IW = $clog2(NUM_WIN);
    localparam logic [31:0] CMAX = 32'((64'd1 << CNT_W) - 64'd1);

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        typedef struct packed {
            logic [CNT_W-1:0] cnt;
        } wc_t;

        wc_t wc_d, wc_q;
        logic [CNT_W-1:0] eff;
        logic             hit;

        always_comb begin
            hit = wr_evt_i && (wr_win_i == IW'(k));
            if (hit) begin
                eff = CNT_W'(sat_inc(32'(wc_q.cnt), CMAX));
            end else begin
                eff = wc_q.cnt;
            end
            wc_d.cnt = eff;
            if (clr_en_i && (clr_idx_i == IW'(k))) begin
                wc_d.cnt = '0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wc_q <= '0;
            end else begin
                wc_q <= wc_d;
            end
        end

        assign eff_o[k*CNT_W +: CNT_W] = eff;
    end

endmodule

// File: rtl/hws_max_pick.sv
module hws_max_pick #(
    parameter int NUM_WIN = 4,
    parameter int CNT_W   = 16
) (
    input  logic [NUM_WIN*CNT_W-1:0]   vals_i,
    output logic [$clog2(NUM_WIN)-1:0] idx_o
);
    localparam int IW = $clog2(NUM_WIN);

    logic [CNT_W-1:0] best;

    always_comb begin
        best  = vals_i[CNT_W-1:0];
        idx_o = '0;
        for (int k = 1; k < NUM_WIN; k++) begin
            // Strict compare keeps the lowest index on a tie.
            if (vals_i[k*CNT_W +: CNT_W] > best) begin
                best  = vals_i[k*CNT_W +: CNT_W];
                idx_o = IW'(k);
            end
        end
    end

endmodule

// File: rtl/hot_window_selector.sv
module hot_window_selector #(
    parameter int NUM_WIN  = 4,
    parameter int CNT_W    = 16,
    parameter int INTERVAL = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_evt_i,
    input  logic [$clog2(NUM_WIN)-1:0] wr_win_i,
    output logic [$clog2(NUM_WIN)-1:0] rsv_win_o,
    output logic                       rsv_valid_o
);
    localparam int IW = $clog2(NUM_WIN);

    typedef struct packed {
        logic [IW-1:0] win;
        logic          valid;
    } sel_t;

    sel_t sel_d, sel_q;

    logic                     boundary;
    logic [NUM_WIN*CNT_W-1:0] eff_flat;
    logic [IW-1:0]            pick_idx;

    hws_interval_timer #(
        .INTERVAL (INTERVAL)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_o (boundary)
    );

    hws_win_counters #(
        .NUM_WIN (NUM_WIN),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_evt_i  (wr_evt_i),
        .wr_win_i  (wr_win_i),
        .clr_en_i  (boundary),
        .clr_idx_i (pick_idx),
        .eff_o     (eff_flat)
    );

    hws_max_pick #(
        .NUM_WIN (NUM_WIN),
        .CNT_W   (CNT_W)
    ) u_pick (
        .vals_i (eff_flat),
        .idx_o  (pick_idx)
    );

    always_comb begin
        sel_d = sel_q;
        if (boundary) begin
            sel_d.win   = pick_idx;
            sel_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign rsv_win_o   = sel_q.win;
    assign rsv_valid_o = sel_q.valid;

endmodule

// File: rtl/hws_checker.sv
module hws_checker #(
    parameter int NUM_WIN  = 4,
    parameter int CNT_W    = 16,
    parameter int INTERVAL = 1024
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_evt_i,
    input logic [$clog2(NUM_WIN)-1:0] wr_win_i,
    input logic [$clog2(NUM_WIN)-1:0] rsv_win_o,
    input logic                       rsv_valid_o,
    input logic [NUM_WIN*CNT_W-1:0]   eff_flat
);
    localparam int IW = $clog2(NUM_WIN);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // Independent cycle count that marks interval ends.
    logic [31:0] cyc_q;
    logic        at_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q == 32'(INTERVAL - 1)) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + 32'd1;
        end
    end

    assign at_end = (cyc_q == 32'(INTERVAL - 1));

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!rsv_valid_o && rsv_win_o == '0));

    a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_valid_o |=> rsv_valid_o);

    a_r2_valid_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        at_end |=> rsv_valid_o);

    a_r3_hold_in_interval: assert property (@(posedge clk) disable iff (!rst_n)
        !at_end |=> ($stable(rsv_win_o) && $stable(rsv_valid_o)));

    a_r8_selected_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        at_end |=> (eff_flat[rsv_win_o*CNT_W +: CNT_W] ==
                    ((wr_evt_i && wr_win_i == rsv_win_o) ? CNT_W'(1) : CNT_W'(0))));

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_chk
        a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (eff_flat[k*CNT_W +: CNT_W] == CMAX && !at_end) |=>
                (eff_flat[k*CNT_W +: CNT_W] == CMAX));

        a_r6_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (!at_end && !(wr_evt_i && wr_win_i == IW'(k))) |=>
                ($past(eff_flat[k*CNT_W +: CNT_W]) <= eff_flat[k*CNT_W +: CNT_W]));
    end

endmodule

bind hot_window_selector hws_checker #(
    .NUM_WIN  (NUM_WIN),
    .CNT_W    (CNT_W),
    .INTERVAL (INTERVAL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_evt_i    (wr_evt_i),
    .wr_win_i    (wr_win_i),
    .rsv_win_o   (rsv_win_o),
    .rsv_valid_o (rsv_valid_o),
    .eff_flat    (eff_flat)
);

// File: tb/hot_window_selector_test.sv
module hot_window_selector_test;

    localparam int CLK_PERIOD = 10;
    localparam int NW  = 4;
    localparam int CW  = 4;
    localparam int IVL = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_evt = 1'b0;
    logic [1:0] wr_win = '0;
    logic [1:0] rsv_win;
    logic       rsv_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    hot_window_selector #(
        .NUM_WIN  (NW),
        .CNT_W    (CW),
        .INTERVAL (IVL)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_evt_i    (wr_evt),
        .wr_win_i    (wr_win),
        .rsv_win_o   (rsv_win),
        .rsv_valid_o (rsv_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [4:0] n0;
        logic [4:0] n1;
        logic [4:0] n2;
        logic [4:0] n3;
        logic [1:0] exp;
    } vec_t;

    // Writes per window in one interval, then the window expected afterwards.
    localparam vec_t VEC [9] = '{
        '{5'd20, 5'd10, 5'd0, 5'd0, 2'd0},  // R7 saturation decides
        '{5'd3,  5'd2,  5'd5, 5'd0, 2'd1},  // R5 history of window 1
        '{5'd0,  5'd0,  5'd0, 5'd9, 2'd3},
        '{5'd2,  5'd5,  5'd0, 5'd5, 2'd0},  // R4 four-way tie
        '{5'd0,  5'd0,  5'd0, 5'd0, 2'd1},  // R4 three-way tie
        '{5'd0,  5'd0,  5'd0, 5'd0, 2'd2},
        '{5'd0,  5'd0,  5'd0, 5'd0, 2'd3},
        '{5'd0,  5'd0,  5'd0, 5'd0, 2'd0},  // R4 all zero
        '{5'd1,  5'd0,  5'd7, 5'd6, 2'd2}
    };

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one interval from its cycle 0; returns in cycle 0 of the next.
    task automatic run_interval(input int n0, input int n1, input int n2,
                                input int n3, input bit bnd_en,
                                input logic [1:0] bnd_win,
                                input bit first, input logic [1:0] prev);
        for (int k = 0; k < IVL; k++) begin
            wr_evt = 1'b0;
            wr_win = 2'd0;
            if (k < n0) begin
                wr_evt = 1'b1; wr_win = 2'd0;
            end else if (k < n0 + n1) begin
                wr_evt = 1'b1; wr_win = 2'd1;
            end else if (k < n0 + n1 + n2) begin
                wr_evt = 1'b1; wr_win = 2'd2;
            end else if (k < n0 + n1 + n2 + n3) begin
                wr_evt = 1'b1; wr_win = 2'd3;
            end
            if (k == IVL - 1) begin
                wr_evt = bnd_en;
                wr_win = bnd_win;
            end
            if (first && (k == 0 || k == IVL - 1)) begin
                check("R2 valid low in first interval", 8'(rsv_valid), 8'd0);
            end
            if (!first && k == IVL / 2) begin
                check("R3 output held mid-interval", 8'(rsv_win), 8'(prev));
            end
            @(negedge clk);
        end
        wr_evt = 1'b0;
        wr_win = 2'd0;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 valid in reset", 8'(rsv_valid), 8'd0);
        @(negedge clk);
        check("R1 window in reset", 8'(rsv_win), 8'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] prev;
        @(negedge clk);
        apply_reset();

        // Table walk, counters carried across intervals.
        prev = 2'd0;
        for (int v = 0; v < 9; v++) begin
            run_interval(int'(VEC[v].n0), int'(VEC[v].n1), int'(VEC[v].n2),
                         int'(VEC[v].n3), 1'b0, 2'd0, (v == 0), prev);
            check("R2 valid after boundary", 8'(rsv_valid), 8'd1);
            check((v == 0) ? "R7 saturating max" :
                  (v >= 3 && v <= 7) ? "R4 tie to lowest" : "R3 R5 max select",
                  8'(rsv_win), 8'(VEC[v].exp));
            prev = VEC[v].exp;
        end

        // Counters now (1,0,0,6). Window 1 to 6, boundary write to window 3.
        run_interval(0, 6, 0, 0, 1'b1, 2'd3, 1'b0, prev);
        check("R8 boundary write counted", 8'(rsv_win), 8'd3);
        // Counters (1,6,0,0): window 1 kept its history.
        run_interval(0, 0, 0, 0, 1'b0, 2'd0, 1'b0, 2'd3);
        check("R5 unselected retained", 8'(rsv_win), 8'd1);
        // Counters (1,0,0,0); one write to window 3 ties at 1 only if cleared.
        run_interval(0, 0, 0, 1, 1'b0, 2'd0, 1'b0, 2'd1);
        check("R8 selected cleared after boundary write", 8'(rsv_win), 8'd0);

        // R6: strobe low has no effect. Counters (0,0,0,1): idle interval picks 3.
        run_interval(0, 0, 0, 0, 1'b0, 2'd0, 1'b0, 2'd0);
        check("R6 idle keeps counts", 8'(rsv_win), 8'd3);

        // Mid-run reset clears state and restarts warm-up.
        @(negedge clk);
        apply_reset();
        run_interval(0, 2, 0, 0, 1'b0, 2'd0, 1'b1, 2'd0);
        check("R2 valid after reset warm-up", 8'(rsv_valid), 8'd1);
        check("R6 single-window increments", 8'(rsv_win), 8'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule